// File: doc/BRIEF.md
# Host Bridge Register Window Decoder

This block sits behind the CPU side of a PCI host bridge and decodes a 16 MiB register window. Every CPU request is steered to exactly one place: the forwarded PCI I/O space, a small relocatable GPIO port, the configuration address register, the configuration data port, or an interrupt-acknowledge read. Requests that match none of these are absorbed. A read returns all ones and a write is dropped. A one-cycle debug flag marks each such request.

The decoder also watches configuration writes aimed at the bridge's own function, which is bus 0, device 0, function 0. A write to register 0x40 there latches a GPIO base value. A later write of 0x11 to register 0x44 places a 4-byte GPIO window at that base plus 0x38 inside I/O space. From then on, I/O accesses to that word go to the GPIO port and not to the PCI forward path.

Requests use a single-cycle request/response bus. The address is a byte offset, and the data is little-endian and lane-aligned: byte lane k is carried on bits 8k+7:8k and is enabled by `req_be[k]`. Each target strobe is driven in the same cycle as the request. The target's read data is taken in that cycle, and the response comes back on the next clock.

Top module: `hbw_window_decode`

## Requirements
- R1: A request with offset below 0xC00000 asserts `io_valid` in the same cycle, with `io_addr` equal to the offset and the enables and write data passed through on `fwd_be`/`fwd_wdata`. A read returns `io_rdata`. This range takes priority over every other decode.
- R2: The word at 0xC00CF8 is the configuration address register. It resets to 0, and a write merges only the enabled byte lanes. Bits 30:24 and 1:0 always read 0. Bit 31 is the enable, bits 23:16 the bus, 15:11 the device, 10:8 the function and 7:2 the register number.
- R3: When the enable bit is 1, an access to the word at 0xE00CFC (offsets 0xE00CFC–0xE00CFF) asserts `cfg_valid`. It presents the bus, device, function and register fields on their ports and passes the byte enables through to select lanes. A read returns `cfg_rdata`.
- R4: When the enable bit is 0, a data-port read returns 0xFFFFFFFF and a data-port write is dropped. Neither raises `cfg_valid` or the unmapped flag.
- R5: A read of the word at 0xF00000 with byte lane 0 enabled asserts `iack_valid` and returns `{24'h0, iack_vector}`.
- R6: Any other request is unmapped. A read returns 0xFFFFFFFF, and a write raises no target strobe. This includes writes to 0xF00000.
- R7: `unmapped_pulse` is high for exactly the response cycle of each unmapped request and is low otherwise.
- R8: `rsp_valid` is high exactly one cycle after each cycle in which `req_valid` is high, with the read data in `rsp_rdata`.
- R9: A configuration data-port write to bus 0, device 0, function 0, register number 0x10 (offset 0x40) merges the enabled lanes into the GPIO base. Writes to any other device leave the base unchanged.
- R10: A configuration data-port write to the bridge function at offset 0x44 maps the GPIO window, but only when lane 0 is enabled and the enabled lanes hold exactly 0x11. The window word is (base + 0x38) with address bits 1:0 dropped, and it replaces any earlier mapping. Other values, and later base changes without a new 0x11 write, leave the mapping as it was.
- R11: Once mapped, an I/O-range access to the window word asserts `gpio_valid` and not `io_valid`, and a read returns `gpio_rdata`. Neighbouring words still go to I/O.
- R12: At most one of `io_valid`, `gpio_valid`, `cfg_valid`, `iack_valid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte offset in the window |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Lane-aligned write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Response read data |
| unmapped_pulse | output | 1 | Unmapped request debug flag |
| fwd_write | output | 1 | Write flag to targets |
| fwd_be | output | 4 | Byte enables to targets |
| fwd_wdata | output | 32 | Write data to targets |
| io_valid | output | 1 | PCI I/O forward strobe |
| io_addr | output | 24 | PCI I/O byte address |
| io_rdata | input | 32 | PCI I/O read data |
| gpio_valid | output | 1 | GPIO port strobe |
| gpio_rdata | input | 32 | GPIO read data |
| cfg_valid | output | 1 | Configuration cycle strobe |
| cfg_bus | output | 8 | Configuration bus number |
| cfg_dev | output | 5 | Configuration device number |
| cfg_fn | output | 3 | Configuration function number |
| cfg_reg | output | 6 | Configuration register number (dword) |
| cfg_rdata | input | 32 | Configuration read data |
| iack_valid | output | 1 | Interrupt acknowledge strobe |
| iack_vector | input | 8 | Vector from the interrupt controller |

## Verification
The main decode is exercised with five kinds of access: I/O offsets at both ends of the forwarded range, the configuration address word with full and partial byte enables, data-port accesses with the enable bit both set and clear, the acknowledge word read and written, and offsets just beside the decoded words. Each of these distinguishes a correct target choice from a neighbouring one, either through the strobe pattern or through the read value (stub data versus all ones). The GPIO relocation is tested with a non-magic value, with the magic value, with a base change that is not followed by a new magic write, with a base write aimed at a different device, and with a second magic write. These show that the window moves only on the magic write and that the old word falls back to I/O.

// File: rtl/hbw_pkg.sv
// Shared types and byte-lane helpers for the host bridge window decoder.
// Assumes a 32-bit, 4-lane little-endian data path.
package hbw_pkg;

    typedef enum logic [2:0] {
        TGT_IO,
        TGT_GPIO,
        TGT_CADDR,
        TGT_CDATA,
        TGT_CDOFF,
        TGT_IACK,
        TGT_NONE
    } hbw_tgt_e;

    // Expand 4 byte enables into a 32-bit bit mask.
    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    // Replace only the enabled lanes of an old word with new data.
    function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                               input logic [31:0] new_w,
                                               input logic [3:0]  be);
        logic [31:0] m;
        m = lane_mask(be);
        return (old_w & ~m) | (new_w & m);
    endfunction

endpackage

// File: rtl/hbw_target_decode.sv
// Combinational target selection for one request.
// Assumes the window offset is a byte address. Decoding is on the word
// address. The I/O range is checked first and wins over everything else.
module hbw_target_decode
    import hbw_pkg::*;
#(
    parameter int          AW        = 24,
    parameter logic [23:0] IO_LIMIT  = 24'hC00000,
    parameter logic [23:0] CADDR_OFS = 24'hC00CF8,
    parameter logic [23:0] CDATA_OFS = 24'hE00CFC,
    parameter logic [23:0] IACK_OFS  = 24'hF00000
) (
    input  logic [AW-1:0] addr,
    input  logic          write,
    input  logic [3:0]    be,
    input  logic          cfg_en,
    input  logic          win_mapped,
    input  logic [AW-3:0] win_word,
    output hbw_tgt_e      tgt
);
    localparam int WAW = AW - 2;
    localparam logic [WAW-1:0] CADDR_W = CADDR_OFS[AW-1:2];
    localparam logic [WAW-1:0] CDATA_W = CDATA_OFS[AW-1:2];
    localparam logic [WAW-1:0] IACK_W  = IACK_OFS[AW-1:2];

    logic [WAW-1:0] word;
    assign word = addr[AW-1:2];

    // Priority decode: I/O space, then the fixed register words, else unmapped.
    always_comb begin
        if (addr < IO_LIMIT[AW-1:0]) begin
            tgt = (win_mapped && word == win_word) ? TGT_GPIO : TGT_IO;
        end else if (word == CADDR_W) begin
            tgt = TGT_CADDR;
        end else if (word == CDATA_W) begin
            tgt = cfg_en ? TGT_CDATA : TGT_CDOFF;
        end else if (word == IACK_W && !write && be[0]) begin
            tgt = TGT_IACK;
        end else begin
            tgt = TGT_NONE;
        end
    end
endmodule

// File: rtl/hbw_cfg_addr_reg.sv
// Configuration address register with byte-lane writes.
// Reserved bits 30:24 and 1:0 are held at zero. Fields are decoded for
// the configuration port.
module hbw_cfg_addr_reg
    import hbw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] value,
    output logic        en,
    output logic [7:0]  bus,
    output logic [4:0]  dev,
    output logic [2:0]  fn,
    output logic [5:0]  regn
);
    localparam logic [31:0] KEEP = 32'h80FF_FFFC;

    // Hold the register; merge enabled lanes on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= lane_merge(value, wdata, be) & KEEP;
        end
    end

    assign en   = value[31];
    assign bus  = value[23:16];
    assign dev  = value[15:11];
    assign fn   = value[10:8];
    assign regn = value[7:2];
endmodule

// File: rtl/hbw_gpio_snoop.sv
// Watches configuration writes to the bridge's own function. It latches
// the GPIO base and maps the GPIO window on the magic value. Assumes
// cfg_wr is high only for enabled data-port writes.
module hbw_gpio_snoop
    import hbw_pkg::*;
#(
    parameter int         AW         = 24,
    parameter logic [7:0] BRIDGE_BUS = 8'd0,
    parameter logic [4:0] BRIDGE_DEV = 5'd0,
    parameter logic [2:0] BRIDGE_FN  = 3'd0,
    parameter logic [7:0] BASE_REG   = 8'h40,
    parameter logic [7:0] MAP_REG    = 8'h44,
    parameter logic [7:0] MAGIC      = 8'h11,
    parameter logic [7:0] WIN_OFS    = 8'h38
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    bus,
    input  logic [4:0]    dev,
    input  logic [2:0]    fn,
    input  logic [5:0]    regn,
    input  logic [3:0]    be,
    input  logic [31:0]   wdata,
    output logic          mapped,
    output logic [AW-3:0] win_word
);
    localparam logic [5:0] BASE_DW = BASE_REG[7:2];
    localparam logic [5:0] MAP_DW  = MAP_REG[7:2];

    logic [31:0] base_q;
    logic [AW-1:0] start;
    logic        own_fn;
    logic        magic_hit;

    assign own_fn    = cfg_wr && bus == BRIDGE_BUS && dev == BRIDGE_DEV && fn == BRIDGE_FN;
    assign magic_hit = own_fn && regn == MAP_DW && be[0]
                       && (wdata & lane_mask(be)) == {24'h0, MAGIC};
    assign start     = base_q[AW-1:0] + {{(AW-8){1'b0}}, WIN_OFS};

    // Latch the GPIO base from writes to the bridge base register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (own_fn && regn == BASE_DW) begin
            base_q <= lane_merge(base_q, wdata, be);
        end
    end

    // Place or re-place the window when the magic value is written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mapped   <= 1'b0;
            win_word <= '0;
        end else if (magic_hit) begin
            mapped   <= 1'b1;
            win_word <= start[AW-1:2];
        end
    end

    AST_MAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |=> mapped); // R10
    AST_WIN_MOVES_ON_MAGIC: assert property (@(posedge clk) disable iff (!rst_n)
        (mapped && !cfg_wr) |=> $stable(win_word)); // R10
endmodule

// File: rtl/hbw_window_decode.sv
// Top of the host bridge register window decoder. It steers each request
// to the I/O forward path, the GPIO port, the configuration address or
// data port, or the interrupt acknowledge. Target read data must be valid
// in the request cycle. The response is registered one cycle later.
module hbw_window_decode
    import hbw_pkg::*;
#(
    parameter int          AW        = 24,
    parameter logic [23:0] IO_LIMIT  = 24'hC00000,
    parameter logic [23:0] CADDR_OFS = 24'hC00CF8,
    parameter logic [23:0] CDATA_OFS = 24'hE00CFC,
    parameter logic [23:0] IACK_OFS  = 24'hF00000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_be,
    input  logic [31:0]   req_wdata,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic          unmapped_pulse,
    output logic          fwd_write,
    output logic [3:0]    fwd_be,
    output logic [31:0]   fwd_wdata,
    output logic          io_valid,
    output logic [AW-1:0] io_addr,
    input  logic [31:0]   io_rdata,
    output logic          gpio_valid,
    input  logic [31:0]   gpio_rdata,
    output logic          cfg_valid,
    output logic [7:0]    cfg_bus,
    output logic [4:0]    cfg_dev,
    output logic [2:0]    cfg_fn,
    output logic [5:0]    cfg_reg,
    input  logic [31:0]   cfg_rdata,
    output logic          iack_valid,
    input  logic [7:0]    iack_vector
);
    hbw_tgt_e      tgt;
    logic [31:0]   caddr_val;
    logic          cfg_en;
    logic          win_mapped;
    logic [AW-3:0] win_word;
    logic          caddr_wr;
    logic [31:0]   rd_next;

    hbw_target_decode #(
        .AW(AW), .IO_LIMIT(IO_LIMIT), .CADDR_OFS(CADDR_OFS),
        .CDATA_OFS(CDATA_OFS), .IACK_OFS(IACK_OFS)
    ) u_dec (
        .addr(req_addr), .write(req_write), .be(req_be), .cfg_en(cfg_en),
        .win_mapped(win_mapped), .win_word(win_word), .tgt(tgt)
    );

    assign caddr_wr = req_valid && req_write && tgt == TGT_CADDR;

    hbw_cfg_addr_reg u_caddr (
        .clk(clk), .rst_n(rst_n), .wr_en(caddr_wr), .be(req_be),
        .wdata(req_wdata), .value(caddr_val), .en(cfg_en), .bus(cfg_bus),
        .dev(cfg_dev), .fn(cfg_fn), .regn(cfg_reg)
    );

    hbw_gpio_snoop #(.AW(AW)) u_snoop (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_valid && req_write),
        .bus(cfg_bus), .dev(cfg_dev), .fn(cfg_fn), .regn(cfg_reg),
        .be(req_be), .wdata(req_wdata), .mapped(win_mapped), .win_word(win_word)
    );

    assign fwd_write  = req_write;
    assign fwd_be     = req_be;
    assign fwd_wdata  = req_wdata;
    assign io_addr    = req_addr;
    assign io_valid   = req_valid && tgt == TGT_IO;
    assign gpio_valid = req_valid && tgt == TGT_GPIO;
    assign cfg_valid  = req_valid && tgt == TGT_CDATA;
    assign iack_valid = req_valid && tgt == TGT_IACK;

    // Select the read value for the chosen target; unmapped reads give all ones.
    always_comb begin
        case (tgt)
            TGT_IO:    rd_next = io_rdata;
            TGT_GPIO:  rd_next = gpio_rdata;
            TGT_CADDR: rd_next = caddr_val;
            TGT_CDATA: rd_next = cfg_rdata;
            TGT_IACK:  rd_next = {24'h0, iack_vector};
            default:   rd_next = '1;
        endcase
    end

    // Register the response and the unmapped debug flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_rdata      <= '0;
            unmapped_pulse <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            unmapped_pulse <= req_valid && tgt == TGT_NONE;
            if (req_valid) begin
                rsp_rdata <= rd_next;
            end
        end
    end

    AST_IO_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> req_addr < IO_LIMIT[AW-1:0]); // R1
    AST_CFG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> caddr_val[31]); // R4
    AST_IACK_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        iack_valid |-> !req_write); // R5
    AST_UNMAPPED_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (unmapped_pulse && !$past(req_write)) |-> rsp_rdata == 32'hFFFF_FFFF); // R6
    AST_UNMAPPED_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_pulse |-> rsp_valid); // R7
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R8
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R8
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_valid, gpio_valid, cfg_valid, iack_valid})); // R12
endmodule

// File: tb/test_hbw_window_decode.sv
`timescale 1ns/1ps
module test_hbw_window_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, unmapped_pulse, fwd_write;
    logic [31:0] rsp_rdata, fwd_wdata;
    logic [3:0]  fwd_be;
    logic        io_valid, gpio_valid, cfg_valid, iack_valid;
    logic [23:0] io_addr;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [5:0]  cfg_reg;
    logic [31:0] io_rdata, gpio_rdata, cfg_rdata;
    logic [7:0]  iack_vector = 8'h2B;

    int checks = 0, failures = 0;
    bit done = 0;

    // Target stubs
    assign io_rdata   = 32'h1000_0000 | {8'h00, io_addr};
    assign gpio_rdata = 32'h6B10_7A00;
    assign cfg_rdata  = {8'hCF, cfg_bus, cfg_dev, cfg_fn, cfg_reg, 2'b00};

    always #2.5 clk = ~clk;

    hbw_window_decode i_hbw_window_decode (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .unmapped_pulse(unmapped_pulse),
        .fwd_write(fwd_write), .fwd_be(fwd_be), .fwd_wdata(fwd_wdata),
        .io_valid(io_valid), .io_addr(io_addr), .io_rdata(io_rdata),
        .gpio_valid(gpio_valid), .gpio_rdata(gpio_rdata),
        .cfg_valid(cfg_valid), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn),
        .cfg_reg(cfg_reg), .cfg_rdata(cfg_rdata),
        .iack_valid(iack_valid), .iack_vector(iack_vector)
    );

    // Captured request-cycle strobes {io,gpio,cfg,iack} and response
    logic [3:0]  s_stb;
    logic [3:0]  s_be;
    logic [31:0] s_wdata;
    logic [23:0] s_ioaddr;
    logic [23:0] s_cfgf;
    logic        r_valid, r_unm;
    logic [31:0] r_data;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request; sample strobes mid-cycle, response one cycle later.
    task automatic acc(input logic w, input logic [23:0] a, input logic [3:0] be,
                       input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = d;
        #1;
        s_stb    = {io_valid, gpio_valid, cfg_valid, iack_valid};
        s_be     = fwd_be;
        s_wdata  = fwd_wdata;
        s_ioaddr = io_addr;
        s_cfgf   = {cfg_bus, cfg_dev, cfg_fn, cfg_reg, 2'b00};
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        r_valid = rsp_valid; r_data = rsp_rdata; r_unm = unmapped_pulse;
    endtask

    task automatic t_reset;
        chk("R8 rsp_valid after reset", {31'h0, rsp_valid}, 0);
        chk("R7 unmapped after reset", {31'h0, unmapped_pulse}, 0);
        acc(0, 24'hC00CF8, 4'hF, 0);
        chk("R2 caddr reset value", r_data, 32'h0);
        chk("R8 response valid", {31'h0, r_valid}, 1);
    endtask

    task automatic t_io;
        acc(0, 24'h000100, 4'hF, 0);
        chk("R12 strobes io read", {28'h0, s_stb}, 4'b1000);
        chk("R1 io read data", r_data, 32'h1000_0100);
        acc(1, 24'hBFFFFE, 4'b1100, 32'hABCD_0000);
        chk("R1 io top strobes", {28'h0, s_stb}, 4'b1000);
        chk("R1 io addr", {8'h0, s_ioaddr}, 32'h00BF_FFFE);
        chk("R1 io be", {28'h0, s_be}, 32'hC);
        chk("R1 io wdata", s_wdata, 32'hABCD_0000);
        chk("R7 no unmapped on io", {31'h0, r_unm}, 0);
    endtask

    task automatic t_caddr;
        acc(1, 24'hC00CF8, 4'hF, 32'hFFFF_FFFF);
        chk("R12 caddr write no strobe", {28'h0, s_stb}, 0);
        acc(0, 24'hC00CF8, 4'hF, 0);
        chk("R2 reserved bits read zero", r_data, 32'h80FF_FFFC);
        acc(1, 24'hC00CF8, 4'b0001, 32'h1234_5610);
        acc(0, 24'hC00CF8, 4'hF, 0);
        chk("R2 byte lane merge", r_data, 32'h80FF_FF10);
    endtask

    task automatic t_cdata_off;
        acc(1, 24'hC00CF8, 4'hF, 32'h0000_0040);
        acc(0, 24'hE00CFC, 4'hF, 0);
        chk("R4 disabled read ones", r_data, 32'hFFFF_FFFF);
        chk("R4 disabled read no strobe", {28'h0, s_stb}, 0);
        chk("R4 disabled no unmapped", {31'h0, r_unm}, 0);
        acc(1, 24'hE00CFD, 4'b0010, 32'h0000_5500);
        chk("R4 disabled write no strobe", {28'h0, s_stb}, 0);
    endtask

    task automatic t_cdata;
        acc(1, 24'hC00CF8, 4'hF, 32'h8002_3A0C);
        acc(0, 24'hE00CFE, 4'b0100, 0);
        chk("R3 cfg strobe", {28'h0, s_stb}, 4'b0010);
        chk("R3 cfg fields", {8'h0, s_cfgf}, 32'h0002_3A0C);
        chk("R3 cfg lane", {28'h0, s_be}, 32'h4);
        chk("R3 cfg read data", r_data, 32'hCF02_3A0C);
    endtask

    task automatic t_iack;
        acc(0, 24'hF00000, 4'b0001, 0);
        chk("R5 iack strobe", {28'h0, s_stb}, 4'b0001);
        chk("R5 iack vector", r_data, 32'h0000_002B);
        acc(1, 24'hF00000, 4'b0001, 32'h99);
        chk("R6 iack write no strobe", {28'h0, s_stb}, 0);
        chk("R7 iack write unmapped", {31'h0, r_unm}, 1);
    endtask

    task automatic t_unmapped;
        acc(0, 24'hD00000, 4'hF, 0);
        chk("R6 unmapped read ones", r_data, 32'hFFFF_FFFF);
        chk("R7 unmapped pulse", {31'h0, r_unm}, 1);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'h0, unmapped_pulse}, 0);
        chk("R8 no response when idle", {31'h0, rsp_valid}, 0);
        acc(0, 24'hC00CFC, 4'hF, 0);
        chk("R6 beside caddr ones", r_data, 32'hFFFF_FFFF);
        acc(1, 24'hE00D00, 4'hF, 32'h1);
        chk("R6 unmapped write no strobe", {28'h0, s_stb}, 0);
        chk("R7 unmapped write pulse", {31'h0, r_unm}, 1);
    endtask

    task automatic t_gpio;
        acc(1, 24'hC00CF8, 4'hF, 32'h8000_0040);
        acc(1, 24'hE00CFC, 4'hF, 32'h0000_1000);   // base = 0x1000
        acc(1, 24'hC00CF8, 4'hF, 32'h8000_0044);
        acc(1, 24'hE00CFC, 4'hF, 32'h0000_0012);   // not magic
        acc(0, 24'h001038, 4'hF, 0);
        chk("R10 non-magic leaves io", {28'h0, s_stb}, 4'b1000);
        acc(1, 24'hC00CF8, 4'hF, 32'h8000_0044);
        acc(1, 24'hE00CFC, 4'hF, 32'h0000_0111);   // not magic
        acc(0, 24'h001038, 4'hF, 0);
        chk("R10 0x111 ignored", {28'h0, s_stb}, 4'b1000);
        acc(1, 24'hC00CF8, 4'hF, 32'h8000_0044);
        acc(1, 24'hE00CFC, 4'b0001, 32'hFFFF_FF11); // magic byte write
        acc(0, 24'h001039, 4'b0010, 0);
        chk("R11 gpio strobe", {28'h0, s_stb}, 4'b0100);
        chk("R11 gpio read data", r_data, 32'h6B10_7A00);
        acc(0, 24'h00103C, 4'hF, 0);
        chk("R11 next word still io", {28'h0, s_stb}, 4'b1000);
        acc(1, 24'hC00CF8, 4'hF, 32'h8000_0040);
        acc(1, 24'hE00CFC, 4'b0010, 32'h0000_2000); // base = 0x2000
        acc(0, 24'h001038, 4'hF, 0);
        chk("R10 base change alone no move", {28'h0, s_stb}, 4'b0100);
        acc(1, 24'hC00CF8, 4'hF, 32'h8000_0844);    // device 1
        acc(1, 24'hE00CFC, 4'hF, 32'h0000_0011);
        acc(1, 24'hC00CF8, 4'hF, 32'h8000_0840);    // device 1 base reg
        acc(1, 24'hE00CFC, 4'hF, 32'h0000_3000);
        acc(0, 24'h001038, 4'hF, 0);
        chk("R9 other device magic no move", {28'h0, s_stb}, 4'b0100);
        acc(1, 24'hC00CF8, 4'hF, 32'h8000_0044);
        acc(1, 24'hE00CFC, 4'hF, 32'h0000_0011);    // remap with base 0x2000
        acc(0, 24'h002038, 4'hF, 0);
        chk("R9 R10 window at new base", {28'h0, s_stb}, 4'b0100);
        acc(0, 24'h001038, 4'hF, 0);
        chk("R10 old window replaced", {28'h0, s_stb}, 4'b1000);
        chk("R10 old window io data", r_data, 32'h1000_1038);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_io();
        t_caddr();
        t_cdata_off();
        t_cdata();
        t_iack();
        t_unmapped();
        t_gpio();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule